// File: doc/BRIEF.md
# Low-Power Mode and Clock-Enable Controller

This block sets the power state of a small microcontroller. It starts in the running state. From there, software picks one of three low-power modes by writing a request code. The modes are a light one (SLEEP), a deeper one (HALT) and a full shutdown (STOP).

Each state drives a fixed pattern of enables:
- the oscillator enable;
- the clock-generator enable;
- the CPU clock enable;
- one clock enable per peripheral: bus controller, 8-bit timer, 16-bit timer, watchdog, serial port, A/D converter and interrupt controller.

In SLEEP, the bus controller goes into a reduced mode. In that mode it only serves memory refresh and external bus requests. This mode is flagged on its own output.

The wake sources depend on the mode. SLEEP wakes on a peripheral interrupt or on an external-pin interrupt. HALT and STOP wake only on an external-pin interrupt. Leaving STOP first restarts the oscillator and the clock generator. The block then holds a stabilisation state for a parameterised number of cycles before it returns to the running state. On every return to the running state, a one-cycle wake pulse tells the CPU to resume.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state code is 0 (running), every clock enable is 1, the bus reduced-mode flag is 0 and the wake pulse is 0.
- R2: In the running state, a valid request with code 1, 2 or 3 moves the block to SLEEP (state 1), HALT (state 2) or STOP (state 3) respectively. The state code changes on the next clock edge.
- R3: A request with code 0 is ignored. A request made in any state other than running is also ignored. In both cases the state code does not change.
- R4: In SLEEP, the oscillator, clock generator, both timers, serial port and A/D enables are 1. The CPU, bus and watchdog enables are 0. The bus reduced-mode flag is 1.
- R5: In HALT, only the oscillator, clock-generator and interrupt-controller enables are 1. Every other enable and the reduced-mode flag are 0.
- R6: In STOP, only the interrupt-controller enable is 1. Every other output enable, including the oscillator and clock generator, is 0.
- R7: In SLEEP, any peripheral interrupt or any external interrupt returns the block to the running state on the next edge.
- R8: In HALT and STOP, peripheral interrupts are ignored and the state does not change.
- R9: In STOP, an external interrupt moves the block to the stabilisation state (code 4). That state has the same enable pattern as HALT. The block stays there for exactly STAB_CYCLES cycles and then returns to the running state. Interrupts and requests have no effect during the stabilisation state.
- R10: The wake output is 1 for exactly the first cycle of the running state after any low-power exit. It is 0 at all other times.
- R11: The interrupt-controller clock enable is 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Mode request strobe from the control register write |
| req_code_i | input | 2 | Requested mode: 1 SLEEP, 2 HALT, 3 STOP, 0 unused |
| periph_irq_i | input | N_PERIPH_IRQ | Peripheral interrupt requests |
| ext_irq_i | input | N_EXT_IRQ | External-pin interrupt requests |
| osc_en_o | output | 1 | Oscillator enable |
| cg_en_o | output | 1 | Clock-generator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| bus_clk_en_o | output | 1 | Bus controller full clock enable |
| bus_lite_o | output | 1 | Bus controller reduced mode (refresh and external requests only) |
| tmr8_clk_en_o | output | 1 | 8-bit timer clock enable |
| tmr16_clk_en_o | output | 1 | 16-bit timer clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| sio_clk_en_o | output | 1 | Serial interface clock enable |
| adc_clk_en_o | output | 1 | A/D converter clock enable |
| intc_clk_en_o | output | 1 | Interrupt controller clock enable |
| wake_o | output | 1 | One-cycle resume pulse to the CPU |
| state_o | output | 3 | State code: 0 run, 1 SLEEP, 2 HALT, 3 STOP, 4 stabilising |

## Verification
The hardest condition to reach is the end of the stabilisation window. The stimulus must show that the running state is not re-entered one cycle early. It must also show that the block does not linger past the window while interrupts keep arriving.

The bench enters STOP from the running state and pulses an external interrupt. It then holds both interrupt kinds active during part of the countdown. It counts the cycles with state code 4 until the return, and expects exactly STAB_CYCLES of them. It also checks that the wake pulse appears on the cycle of the return and not before.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_SLEEP = 3'd1,
    PM_HALT  = 3'd2,
    PM_STOP  = 3'd3,
    PM_STAB  = 3'd4
  } pm_state_e;

  localparam logic [1:0] REQ_SLEEP = 2'd1;
  localparam logic [1:0] REQ_HALT  = 2'd2;
  localparam logic [1:0] REQ_STOP  = 2'd3;

  // enable vector bit positions
  localparam int G_INTC  = 0;
  localparam int G_ADC   = 1;
  localparam int G_SIO   = 2;
  localparam int G_WDT   = 3;
  localparam int G_TMR16 = 4;
  localparam int G_TMR8  = 5;
  localparam int G_LITE  = 6;
  localparam int G_BUS   = 7;
  localparam int G_CPU   = 8;
  localparam int G_CG    = 9;
  localparam int G_OSC   = 10;
  localparam int GATE_W  = 11;

  function automatic logic [GATE_W-1:0] gate_pattern(pm_state_e s);
    logic [GATE_W-1:0] g;
    g = '0;
    g[G_INTC] = 1'b1;
    case (s)
      PM_RUN: begin
        g = '1;
        g[G_LITE] = 1'b0;
      end
      PM_SLEEP: begin
        g[G_OSC] = 1'b1; g[G_CG] = 1'b1; g[G_LITE] = 1'b1;
        g[G_TMR8] = 1'b1; g[G_TMR16] = 1'b1;
        g[G_SIO] = 1'b1; g[G_ADC] = 1'b1;
      end
      PM_HALT, PM_STAB: begin
        g[G_OSC] = 1'b1; g[G_CG] = 1'b1;
      end
      default: ;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/pwr_stab_cnt.sv
module pwr_stab_cnt #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  generate
    if (STAB_CYCLES > 1) begin : g_cnt
      localparam int CW = $clog2(STAB_CYCLES);
      localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYCLES - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (load_i)          cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end
      assign done_o = (cnt_q == '0);
    end else begin : g_nocnt
      assign done_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_code_i,
  input  logic       periph_any_i,
  input  logic       ext_any_i,
  input  logic       stab_done_i,
  output pm_state_e  state_o,
  output logic       stab_load_o,
  output logic       wake_o
);
  pm_state_e state_q, state_d;
  logic      wake_q;

  always_comb begin
    state_d     = state_q;
    stab_load_o = 1'b0;
    case (state_q)
      PM_RUN: if (req_valid_i) begin
        case (req_code_i)
          REQ_SLEEP: state_d = PM_SLEEP;
          REQ_HALT:  state_d = PM_HALT;
          REQ_STOP:  state_d = PM_STOP;
          default:   state_d = PM_RUN;
        endcase
      end
      PM_SLEEP: if (periph_any_i || ext_any_i) state_d = PM_RUN;
      PM_HALT:  if (ext_any_i) state_d = PM_RUN;
      PM_STOP:  if (ext_any_i) begin
        state_d     = PM_STAB;
        stab_load_o = 1'b1;
      end
      PM_STAB:  if (stab_done_i) state_d = PM_RUN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_d == PM_RUN) && (state_q != PM_RUN);
    end
  end

  assign state_o = state_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/pwr_gate_map.sv
module pwr_gate_map
  import pwr_mode_pkg::*;
(
  input  pm_state_e         state_i,
  output logic [GATE_W-1:0] gate_o
);
  assign gate_o = gate_pattern(state_i);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH_IRQ = 8,
  parameter int N_EXT_IRQ    = 4,
  parameter int STAB_CYCLES  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [1:0]              req_code_i,
  input  logic [N_PERIPH_IRQ-1:0] periph_irq_i,
  input  logic [N_EXT_IRQ-1:0]    ext_irq_i,
  output logic                    osc_en_o,
  output logic                    cg_en_o,
  output logic                    cpu_clk_en_o,
  output logic                    bus_clk_en_o,
  output logic                    bus_lite_o,
  output logic                    tmr8_clk_en_o,
  output logic                    tmr16_clk_en_o,
  output logic                    wdt_clk_en_o,
  output logic                    sio_clk_en_o,
  output logic                    adc_clk_en_o,
  output logic                    intc_clk_en_o,
  output logic                    wake_o,
  output logic [2:0]              state_o
);
  pm_state_e         state;
  logic              stab_load, stab_done;
  logic [GATE_W-1:0] gate;

  pwr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_code_i   (req_code_i),
    .periph_any_i (|periph_irq_i),
    .ext_any_i    (|ext_irq_i),
    .stab_done_i  (stab_done),
    .state_o      (state),
    .stab_load_o  (stab_load),
    .wake_o       (wake_o)
  );

  pwr_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stab_load),
    .done_o (stab_done)
  );

  pwr_gate_map u_map (
    .state_i (state),
    .gate_o  (gate)
  );

  assign state_o        = state;
  assign osc_en_o       = gate[G_OSC];
  assign cg_en_o        = gate[G_CG];
  assign cpu_clk_en_o   = gate[G_CPU];
  assign bus_clk_en_o   = gate[G_BUS];
  assign bus_lite_o     = gate[G_LITE];
  assign tmr8_clk_en_o  = gate[G_TMR8];
  assign tmr16_clk_en_o = gate[G_TMR16];
  assign wdt_clk_en_o   = gate[G_WDT];
  assign sio_clk_en_o   = gate[G_SIO];
  assign adc_clk_en_o   = gate[G_ADC];
  assign intc_clk_en_o  = gate[G_INTC];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_PERIPH_IRQ = 8,
  parameter int N_EXT_IRQ    = 4,
  parameter int STAB_CYCLES  = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic [1:0]              req_code_i,
  input logic [N_PERIPH_IRQ-1:0] periph_irq_i,
  input logic [N_EXT_IRQ-1:0]    ext_irq_i,
  input logic                    osc_en_o,
  input logic                    cg_en_o,
  input logic                    cpu_clk_en_o,
  input logic                    intc_clk_en_o,
  input logic                    wake_o,
  input logic [2:0]              state_o
);
  localparam int SCW = $clog2(STAB_CYCLES + 1) + 1;
  logic [SCW-1:0] stab_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              stab_cyc <= '0;
    else if (state_o == 3'd4) stab_cyc <= stab_cyc + 1'b1;
    else                      stab_cyc <= '0;
  end

  AST_BAD_REQ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && (!req_valid_i || req_code_i == 2'd0)) |=> state_o == 3'd0); // R3
  AST_STOP_CLOCKS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> (!osc_en_o && !cg_en_o && !cpu_clk_en_o)); // R6
  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && (|periph_irq_i || |ext_irq_i)) |=> state_o == 3'd0); // R7
  AST_PERIPH_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == 3'd2 || state_o == 3'd3) && !(|ext_irq_i)) |=> $stable(state_o)); // R8
  AST_STAB_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && stab_cyc != SCW'(STAB_CYCLES - 1)) |=> state_o == 3'd4); // R9
  AST_STAB_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4) |-> stab_cyc < SCW'(STAB_CYCLES)); // R9
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R10
  AST_WAKE_ON_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> state_o == 3'd0); // R10
  AST_INTC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intc_clk_en_o); // R11
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .N_PERIPH_IRQ (N_PERIPH_IRQ),
  .N_EXT_IRQ    (N_EXT_IRQ),
  .STAB_CYCLES  (STAB_CYCLES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_code_i    (req_code_i),
  .periph_irq_i  (periph_irq_i),
  .ext_irq_i     (ext_irq_i),
  .osc_en_o      (osc_en_o),
  .cg_en_o       (cg_en_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .intc_clk_en_o (intc_clk_en_o),
  .wake_o        (wake_o),
  .state_o       (state_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int NP = 8;
  localparam int NE = 4;
  localparam int STAB = 16;

  // expected enables {osc,cg,cpu,bus,lite,tmr8,tmr16,wdt,sio,adc,intc}
  localparam logic [10:0] P_RUN   = 11'b11110111111;
  localparam logic [10:0] P_SLEEP = 11'b11001110111;
  localparam logic [10:0] P_HALT  = 11'b11000000001;
  localparam logic [10:0] P_STOP  = 11'b00000000001;

  typedef struct packed {
    logic [1:0]  code;
    logic [1:0]  irq;      // 1 peripheral, 2 external
    logic [2:0]  mode;
    logic [10:0] pat;
    logic [2:0]  after;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 2'd1, 3'd1, P_SLEEP, 3'd0},
    '{2'd1, 2'd2, 3'd1, P_SLEEP, 3'd0},
    '{2'd2, 2'd1, 3'd2, P_HALT,  3'd2},
    '{2'd2, 2'd2, 3'd2, P_HALT,  3'd0},
    '{2'd3, 2'd1, 3'd3, P_STOP,  3'd3},
    '{2'd3, 2'd2, 3'd3, P_STOP,  3'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_code = '0;
  logic [NP-1:0] pirq = '0;
  logic [NE-1:0] eirq = '0;
  logic osc, cg, cpu, bus, lite, t8, t16, wdt, sio, adc, intc, wake;
  logic [2:0] state;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.N_PERIPH_IRQ(NP), .N_EXT_IRQ(NE), .STAB_CYCLES(STAB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_code_i(req_code),
    .periph_irq_i(pirq), .ext_irq_i(eirq),
    .osc_en_o(osc), .cg_en_o(cg), .cpu_clk_en_o(cpu), .bus_clk_en_o(bus),
    .bus_lite_o(lite), .tmr8_clk_en_o(t8), .tmr16_clk_en_o(t16),
    .wdt_clk_en_o(wdt), .sio_clk_en_o(sio), .adc_clk_en_o(adc),
    .intc_clk_en_o(intc), .wake_o(wake), .state_o(state)
  );

  wire [10:0] pat = {osc, cg, cpu, bus, lite, t8, t16, wdt, sio, adc, intc};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic request(logic [1:0] c);
    req_valid = 1'b1; req_code = c;
    tick();
    req_valid = 1'b0; req_code = '0;
  endtask

  task automatic to_run_from_stop();
    eirq = 4'b0001;
    tick();
    eirq = '0;
    repeat (STAB) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 state", state, 3'd0);
    chk("R1 pattern", pat, P_RUN);
    chk("R1 wake", wake, 1'b0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      request(v.code);
      chk("R2 mode entry", state, v.mode);
      chk(v.mode == 3'd1 ? "R4 sleep gating" : v.mode == 3'd2 ? "R5 halt gating" : "R6 stop gating",
          pat, v.pat);
      chk("R11 intc on", intc, 1'b1);
      if (v.irq == 2'd1) pirq = 8'h40; else eirq = 4'b1000;
      tick();
      pirq = '0; eirq = '0;
      chk(v.mode == 3'd1 ? "R7 sleep wake" : v.irq == 2'd1 ? "R8 periph ignored" : "R9 ext wake",
          state, v.after);
      if (v.after == 3'd0) begin
        chk("R10 wake pulse", wake, 1'b1);
        tick();
        chk("R10 wake single", wake, 1'b0);
      end else if (v.after == 3'd4) begin
        int n;
        chk("R9 stab gating", pat, P_HALT);
        chk("R10 no wake in stab", wake, 1'b0);
        n = 1;
        pirq = 8'hff; eirq = 4'hf;
        while (state == 3'd4 && n < 100) begin
          tick();
          if (n == 4) begin pirq = '0; eirq = '0; end
          if (state == 3'd4) n++;
        end
        pirq = '0; eirq = '0;
        chk("R9 stab length", n, STAB);
        chk("R9 back to run", state, 3'd0);
        chk("R10 wake after stab", wake, 1'b1);
        tick();
      end else begin
        chk("R10 no wake while parked", wake, 1'b0);
        if (v.mode == 3'd3) to_run_from_stop();
        else begin eirq = 4'b0010; tick(); eirq = '0; end
        chk("R8 ext recovers", state, 3'd0);
        tick();
      end
    end

    // R3 unused code ignored
    request(2'd0);
    chk("R3 code0 ignored", state, 3'd0);
    chk("R3 code0 pattern", pat, P_RUN);
    // R3 request outside running ignored
    request(2'd1);
    request(2'd3);
    chk("R3 req in sleep ignored", state, 3'd1);
    request(2'd2);
    chk("R3 req in sleep ignored", state, 3'd1);
    pirq = 8'h01; tick(); pirq = '0;
    chk("R7 periph wakes sleep", state, 3'd0);
    tick();
    request(2'd2);
    request(2'd3);
    chk("R3 req in halt ignored", state, 3'd2);
    eirq = 4'b0100; tick(); eirq = '0;
    chk("R5 halt exit", state, 3'd0);
    tick();
    // R3 request during stabilisation ignored
    request(2'd3);
    eirq = 4'b0001; tick(); eirq = '0;
    request(2'd2);
    chk("R3 req in stab ignored", state, 3'd4);
    repeat (STAB - 1) tick();
    chk("R9 run after window", state, 3'd0);
    chk("R10 final wake", wake, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule